// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a write-through cache and the next memory level. The processor hands it single-word stores and moves on without waiting. Storage is organised as a small ring of block-sized slots. Each slot holds one aligned group of consecutive words and one valid flag per word. A new store whose block is already held in a slot is folded into that slot and takes no new one. As a result, the memory side sees one multi-word write with a word-enable mask instead of a string of single-word writes.

Slots leave in the order they were created. A slot is released when the ring holds enough slots, when every word of the oldest slot is valid, or when the oldest slot has waited long enough. Until then, later stores to the same block can still join it. Loads look into the buffer first and are served from it when the word is pending. Otherwise the load goes to memory ahead of any write that has not yet been offered.

All addresses are word addresses. The low `log2(WORDS)` bits select the word inside a block, and the remaining bits form the block tag.

Top module: `merge_wbuf`

## Requirements
- R1: `wr_ready` is high whenever a free slot exists or the store's block matches a slot that may be merged into. It is low only when all ENTRIES slots are occupied and no mergeable slot matches. A store is taken on any cycle where `wr_valid` and `wr_ready` are both high.
- R2: A store whose block tag equals the tag of an occupied slot that is not being offered to memory joins that slot. It does not occupy a new one.
- R3: A merged store replaces the word at its offset with the new data and sets that word's valid flag. Words already valid at other offsets keep their values.
- R4: The oldest slot stops accepting merges while it is offered to memory. A store to its block in that period starts a new slot.
- R5: Slots drain oldest first. Each drain is one command with `mem_cmd_we`=1 and `mem_cmd_addr` equal to the block tag followed by zero offset bits. Bit k of `mem_cmd_wmask` marks word k valid, and that word's data sits in `mem_cmd_wdata[32k+31:32k]`. Only masked words carry meaning.
- R6: The oldest slot is offered when the buffer holds at least DRAIN_THRESH (default 2) slots, or when all its word flags are set, or after AGE_LIMIT (default 16) clock edges as oldest. A lone partial slot is not offered before that.
- R7: A load whose word is valid in some slot gets `rd_ack` in the same cycle as `rd_req`, with the data from the youngest slot holding that word.
- R8: A load whose word is not valid in any slot, including a word missing from a partially filled slot, issues a command with `mem_cmd_we`=0 and `mem_cmd_addr`=`rd_addr`. `rd_ack` and `rd_data` follow in the cycle where `mem_rsp_valid` is high.
- R9: A load miss takes the memory port ahead of a drain that has not yet been offered. A drain that is offered and not accepted keeps its address, data and mask unchanged until it is accepted.
- R10: After reset the buffer is empty: `wr_ready`=1, `mem_cmd_valid`=0 and `rd_ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Store accepted this cycle |
| wr_addr | input | ADDR_W | Store word address |
| wr_data | input | DATA_W | Store data |
| rd_req | input | 1 | Load request, held until `rd_ack` |
| rd_addr | input | ADDR_W | Load word address |
| rd_ack | output | 1 | Load data valid |
| rd_data | output | DATA_W | Load data |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_we | output | 1 | 1 = block write, 0 = word read |
| mem_cmd_addr | output | ADDR_W | Command word address |
| mem_cmd_wdata | output | WORDS*DATA_W | Block write data |
| mem_cmd_wmask | output | WORDS | Per-word write enable |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Read data |

## Verification
The hardest state to reach is a store aimed at the block of a slot that is currently offered to memory. Reaching it needs the memory side stalled while the buffer holds enough slots to trigger a drain. The stimulus table keeps `mem_cmd_ready` low, fills two slots so the oldest is offered, and then stores again into the offered block. It then reads back from both copies and lets the ring drain, so the split into two commands can be seen. The lone-slot age release and the read-before-drain race are each driven by directed sequences timed against the cycle count.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;

    function automatic logic [3:0] bit_of(input int unsigned pos);
        return 4'(1) << pos;
    endfunction

endpackage

// File: rtl/mwb_match.sv
module mwb_match #(
    parameter int ENTRIES = 4,
    parameter int BLK_W   = 30
) (
    input  logic [ENTRIES-1:0]            live,
    input  logic [ENTRIES-1:0][BLK_W-1:0] tags,
    input  logic [ENTRIES-1:0]            skip,
    input  logic [BLK_W-1:0]              probe,
    output logic [ENTRIES-1:0]            hits
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = live[g] && !skip[g] && (tags[g] == probe);
    end

endmodule

// File: rtl/mwb_fwd.sv
module mwb_fwd #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int BLK_W   = 30,
    parameter int PTR_W   = 2,
    parameter int OFF_W   = 2
) (
    input  logic [ENTRIES-1:0]                        live,
    input  logic [ENTRIES-1:0][BLK_W-1:0]             tags,
    input  logic [ENTRIES-1:0][WORDS-1:0]             masks,
    input  logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0] data,
    input  logic [PTR_W-1:0]                          head,
    input  logic [BLK_W-1:0]                          probe_blk,
    input  logic [OFF_W-1:0]                          probe_off,
    output logic                                      hit,
    output logic [DATA_W-1:0]                         word
);

    logic [PTR_W-1:0] idx;

    // Scan from oldest to youngest so the youngest copy wins.
    always_comb begin
        hit  = 1'b0;
        word = '0;
        idx  = head;
        for (int k = 0; k < ENTRIES; k++) begin
            idx = head + PTR_W'(k);
            if (live[idx] && (tags[idx] == probe_blk) && masks[idx][probe_off]) begin
                hit  = 1'b1;
                word = data[idx][probe_off];
            end
        end
    end

endmodule

// File: rtl/mwb_arb.sv
module mwb_arb
    import mwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic rd_hit,
    input  logic drain_want,
    input  logic mem_ready,
    input  logic mem_rsp_valid,
    output logic issue_rd,
    output logic issue_wr,
    output logic rd_ack,
    output logic rd_wait
);

    rd_state_e rd_q;
    logic      busy_q;
    logic      rd_miss;

    assign rd_miss  = (rd_q == RD_IDLE) && rd_req && !rd_hit;
    assign issue_rd = !busy_q && rd_miss;
    assign issue_wr = busy_q || (!rd_miss && drain_want);
    assign rd_wait  = (rd_q == RD_WAIT);
    assign rd_ack   = ((rd_q == RD_IDLE) && rd_req && rd_hit) ||
                      ((rd_q == RD_WAIT) && mem_rsp_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= RD_IDLE;
            busy_q <= 1'b0;
        end else begin
            busy_q <= issue_wr && !mem_ready;
            case (rd_q)
                RD_IDLE: if (issue_rd && mem_ready) rd_q <= RD_WAIT;
                RD_WAIT: if (mem_rsp_valid)         rd_q <= RD_IDLE;
                default: rd_q <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import mwb_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int WORDS        = 4,
    parameter int ENTRIES      = 4,
    parameter int DRAIN_THRESH = 2,
    parameter int AGE_LIMIT    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    rd_req,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_ack,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    mem_cmd_valid,
    input  logic                    mem_cmd_ready,
    output logic                    mem_cmd_we,
    output logic [ADDR_W-1:0]       mem_cmd_addr,
    output logic [WORDS*DATA_W-1:0] mem_cmd_wdata,
    output logic [WORDS-1:0]        mem_cmd_wmask,
    input  logic                    mem_rsp_valid,
    input  logic [DATA_W-1:0]       mem_rsp_data
);

    localparam int OFF_W = $clog2(WORDS);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int PTR_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1);

    // Slot storage
    logic [ENTRIES-1:0]                        live_q;
    logic [ENTRIES-1:0][BLK_W-1:0]             tag_q;
    logic [ENTRIES-1:0][WORDS-1:0]             mask_q;
    logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0] data_q;
    logic [PTR_W-1:0]                          head_q, tail_q;
    logic [CNT_W-1:0]                          count_q;
    logic [AGE_W-1:0]                          age_q;

    logic [BLK_W-1:0]   wr_blk, rd_blk;
    logic [OFF_W-1:0]   wr_off, rd_off;
    logic [ENTRIES-1:0] skip, merge_vec;
    logic               merge_hit, full, wr_fire, alloc, pop;
    logic               drain_want, issue_rd, issue_wr, rd_wait;
    logic               fwd_hit;
    logic [DATA_W-1:0]  fwd_word;

    assign wr_blk = wr_addr[ADDR_W-1:OFF_W];
    assign wr_off = wr_addr[OFF_W-1:0];
    assign rd_blk = rd_addr[ADDR_W-1:OFF_W];
    assign rd_off = rd_addr[OFF_W-1:0];

    assign drain_want = (count_q != '0) &&
                        ((count_q >= CNT_W'(DRAIN_THRESH)) ||
                         (&mask_q[head_q]) ||
                         (age_q == AGE_W'(AGE_LIMIT)));

    // The slot on offer to memory is frozen against merges.
    assign skip = issue_wr ? (ENTRIES'(1) << head_q) : '0;

    mwb_match #(
        .ENTRIES(ENTRIES),
        .BLK_W  (BLK_W)
    ) u_match (
        .live (live_q),
        .tags (tag_q),
        .skip (skip),
        .probe(wr_blk),
        .hits (merge_vec)
    );

    mwb_fwd #(
        .ENTRIES(ENTRIES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .BLK_W  (BLK_W),
        .PTR_W  (PTR_W),
        .OFF_W  (OFF_W)
    ) u_fwd (
        .live     (live_q),
        .tags     (tag_q),
        .masks    (mask_q),
        .data     (data_q),
        .head     (head_q),
        .probe_blk(rd_blk),
        .probe_off(rd_off),
        .hit      (fwd_hit),
        .word     (fwd_word)
    );

    mwb_arb u_arb (
        .clk          (clk),
        .rst          (rst),
        .rd_req       (rd_req),
        .rd_hit       (fwd_hit),
        .drain_want   (drain_want),
        .mem_ready    (mem_cmd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .issue_rd     (issue_rd),
        .issue_wr     (issue_wr),
        .rd_ack       (rd_ack),
        .rd_wait      (rd_wait)
    );

    assign merge_hit = |merge_vec;
    assign full      = (count_q == CNT_W'(ENTRIES));
    assign wr_ready  = merge_hit || !full;
    assign wr_fire   = wr_valid && wr_ready;
    assign alloc     = wr_fire && !merge_hit;
    assign pop       = issue_wr && mem_cmd_ready;

    assign mem_cmd_valid = issue_rd || issue_wr;
    assign mem_cmd_we    = issue_wr;
    assign mem_cmd_addr  = issue_wr ? {tag_q[head_q], {OFF_W{1'b0}}} : rd_addr;
    assign mem_cmd_wdata = data_q[head_q];
    assign mem_cmd_wmask = mask_q[head_q];

    assign rd_data = rd_wait ? mem_rsp_data : fwd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= '0;
            tag_q   <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            age_q   <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (pop && (head_q == PTR_W'(i))) begin
                    live_q[i] <= 1'b0;
                    mask_q[i] <= '0;
                end
                if (wr_fire && merge_vec[i]) begin
                    mask_q[i][wr_off] <= 1'b1;
                    data_q[i][wr_off] <= wr_data;
                end
                if (alloc && (tail_q == PTR_W'(i))) begin
                    live_q[i]         <= 1'b1;
                    tag_q[i]          <= wr_blk;
                    mask_q[i]         <= WORDS'(1) << wr_off;
                    data_q[i][wr_off] <= wr_data;
                end
            end
            head_q  <= head_q + PTR_W'(pop);
            tail_q  <= tail_q + PTR_W'(alloc);
            count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop);
            if (pop || (count_q == '0))
                age_q <= '0;
            else if (age_q != AGE_W'(AGE_LIMIT))
                age_q <= age_q + AGE_W'(1);
        end
    end

endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int WORDS   = 4,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_valid,
    input logic                    wr_ready,
    input logic                    mem_cmd_valid,
    input logic                    mem_cmd_ready,
    input logic                    mem_cmd_we,
    input logic [ADDR_W-1:0]       mem_cmd_addr,
    input logic [WORDS*DATA_W-1:0] mem_cmd_wdata,
    input logic [WORDS-1:0]        mem_cmd_wmask,
    input logic                    mem_rsp_valid,
    input logic                    rd_ack,
    input logic                    rd_wait,
    input logic [CNT_W-1:0]        count,
    input logic [ENTRIES-1:0]      merge_vec
);

    localparam int OFF_W = $clog2(WORDS);

    logic pop;
    assign pop = mem_cmd_valid && mem_cmd_ready && mem_cmd_we;

    p_stall_only_full_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |-> (count == CNT_W'(ENTRIES)));

    p_single_merge_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(merge_vec));

    p_merge_no_alloc_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && (merge_vec != '0) && !pop) |=> (count == $past(count)));

    p_drain_shape_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_we) |->
            ((mem_cmd_wmask != '0) && (mem_cmd_addr[OFF_W-1:0] == '0) && (count != '0)));

    p_rsp_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_wait && mem_rsp_valid) |-> rd_ack);

    p_offer_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd_valid && mem_cmd_we && !mem_cmd_ready) |=>
            (mem_cmd_valid && mem_cmd_we && $stable(mem_cmd_addr) &&
             $stable(mem_cmd_wdata) && $stable(mem_cmd_wmask)));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ENTRIES));

endmodule

bind merge_wbuf mwb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .ENTRIES(ENTRIES),
    .CNT_W  (CNT_W)
) u_mwb_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .mem_cmd_valid(mem_cmd_valid),
    .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_we   (mem_cmd_we),
    .mem_cmd_addr (mem_cmd_addr),
    .mem_cmd_wdata(mem_cmd_wdata),
    .mem_cmd_wmask(mem_cmd_wmask),
    .mem_rsp_valid(mem_rsp_valid),
    .rd_ack       (rd_ack),
    .rd_wait      (rd_wait),
    .count        (count_q),
    .merge_vec    (merge_vec)
);

// File: tb/tb_merge_wbuf.sv
module tb_merge_wbuf;

    localparam logic [31:0] KEY = 32'h5A5A_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [31:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         rd_req = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic         rd_ack;
    logic [31:0]  rd_data;
    logic         mem_cmd_valid;
    logic         mem_cmd_ready = 1'b0;
    logic         mem_cmd_we;
    logic [31:0]  mem_cmd_addr;
    logic [127:0] mem_cmd_wdata;
    logic [3:0]   mem_cmd_wmask;
    logic         mem_rsp_valid;
    logic [31:0]  mem_rsp_data;

    always #10 clk = ~clk;

    merge_wbuf dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready), .mem_cmd_we(mem_cmd_we),
        .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata), .mem_cmd_wmask(mem_cmd_wmask),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Memory model: reads answer one cycle after acceptance with addr ^ KEY.
    logic        rsp_pend = 1'b0, rsp_q = 1'b0;
    logic [31:0] rsp_addr_n = '0, rsp_addr_q = '0;
    always @(negedge clk) begin
        rsp_pend   <= mem_cmd_valid && mem_cmd_ready && !mem_cmd_we;
        rsp_addr_n <= mem_cmd_addr;
    end
    always @(posedge clk) begin
        rsp_q      <= rsp_pend;
        rsp_addr_q <= rsp_addr_n;
    end
    assign mem_rsp_valid = rsp_q;
    assign mem_rsp_data  = rsp_addr_q ^ KEY;

    // Log of accepted block writes
    logic [31:0]  log_addr [32];
    logic [127:0] log_data [32];
    logic [3:0]   log_mask [32];
    int           log_n = 0;
    always @(negedge clk) begin
        if (mem_cmd_valid && mem_cmd_ready && mem_cmd_we && log_n < 32) begin
            log_addr[log_n] = mem_cmd_addr;
            log_data[log_n] = mem_cmd_wdata;
            log_mask[log_n] = mem_cmd_wmask;
            log_n++;
        end
    end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_drain(input int idx, input logic [31:0] a, input logic [3:0] m,
                             input logic [127:0] d, input string tag);
        logic [127:0] sel;
        sel = {{32{m[3]}}, {32{m[2]}}, {32{m[1]}}, {32{m[0]}}};
        chk(idx < log_n, {tag, " drain present"}, 128'(log_n), 128'(idx + 1));
        if (idx < log_n) begin
            chk(log_addr[idx] == a && log_mask[idx] == m, {tag, " drain addr/mask"},
                {log_addr[idx], 4'h0, log_mask[idx]}, {a, 4'h0, m});
            chk((log_data[idx] & sel) == (d & sel), {tag, " drain data"},
                log_data[idx] & sel, d & sel);
        end
    endtask

    typedef struct packed {
        logic        is_rd;
        logic [15:0] addr;
        logic [31:0] data;
        logic        exp;
    } vec_t;

    // Memory stalled throughout; writes check wr_ready, reads check hit data.
    localparam vec_t VEC [13] = '{
        '{1'b0, 16'h0010, 32'h1000_0001, 1'b1},
        '{1'b0, 16'h0011, 32'h1000_0002, 1'b1},
        '{1'b1, 16'h0010, 32'h1000_0001, 1'b1},
        '{1'b0, 16'h0010, 32'h1000_0003, 1'b1},
        '{1'b1, 16'h0010, 32'h1000_0003, 1'b1},
        '{1'b0, 16'h0020, 32'h1000_0004, 1'b1},
        '{1'b0, 16'h0012, 32'h1000_0005, 1'b1},
        '{1'b1, 16'h0012, 32'h1000_0005, 1'b1},
        '{1'b1, 16'h0011, 32'h1000_0002, 1'b1},
        '{1'b1, 16'h0010, 32'h1000_0003, 1'b1},
        '{1'b0, 16'h0030, 32'h1000_0006, 1'b1},
        '{1'b0, 16'h0021, 32'h1000_0007, 1'b1},
        '{1'b0, 16'h0040, 32'h1000_0008, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        int early;
        bit seen;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(wr_ready == 1'b1, "R10 wr_ready after reset", 128'(wr_ready), 128'(1));
        chk(mem_cmd_valid == 1'b0, "R10 no command after reset", 128'(mem_cmd_valid), 128'(0));
        chk(rd_ack == 1'b0, "R10 no ack after reset", 128'(rd_ack), 128'(0));

        // Table walk: R1 R2 R3 R4 R7 with memory stalled
        for (int i = 0; i < 13; i++) begin
            @(posedge clk);
            #1;
            if (VEC[i].is_rd) begin
                wr_valid = 1'b0;
                rd_req   = 1'b1;
                rd_addr  = {16'h0, VEC[i].addr};
            end else begin
                rd_req   = 1'b0;
                wr_valid = 1'b1;
                wr_addr  = {16'h0, VEC[i].addr};
                wr_data  = VEC[i].data;
            end
            @(negedge clk);
            if (VEC[i].is_rd)
                chk(rd_ack && rd_data == VEC[i].data, "R7 buffered read hit",
                    {rd_ack, rd_data}, {1'b1, VEC[i].data});
            else
                chk(wr_ready == VEC[i].exp, "R1 write accept", 128'(wr_ready), 128'(VEC[i].exp));
        end
        @(posedge clk);
        #1 wr_valid = 1'b0;
        rd_req = 1'b0;

        // Release memory; R2 R3 R4 R5 drain order and contents
        base = log_n;
        mem_cmd_ready = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(log_n - base == 4, "R5 drain count (R2 merges)", 128'(log_n - base), 128'(4));
        chk_drain(base + 0, 32'h10, 4'b0011, {64'h0, 32'h1000_0002, 32'h1000_0003}, "R3 R5 slot A");
        chk_drain(base + 1, 32'h20, 4'b0011, {64'h0, 32'h1000_0007, 32'h1000_0004}, "R2 R5 slot B");
        chk_drain(base + 2, 32'h10, 4'b0100, {32'h0, 32'h1000_0005, 64'h0}, "R4 R5 split slot");
        chk_drain(base + 3, 32'h30, 4'b0001, {96'h0, 32'h1000_0006}, "R5 slot C");
        chk(wr_ready == 1'b1, "R1 ready after drain", 128'(wr_ready), 128'(1));

        // R8 R9: partial-block miss goes to memory ahead of a wanted drain
        base = log_n;
        @(posedge clk); #1 wr_valid = 1'b1; wr_addr = 32'h50; wr_data = 32'hAAAA_0050;
        @(posedge clk); #1 wr_addr = 32'h70; wr_data = 32'hAAAA_0070;
        @(posedge clk); #1 wr_valid = 1'b0; rd_req = 1'b1; rd_addr = 32'h51;
        @(negedge clk);
        chk(mem_cmd_valid && !mem_cmd_we && mem_cmd_addr == 32'h51, "R9 read before drain",
            {mem_cmd_valid, mem_cmd_we, mem_cmd_addr}, {1'b1, 1'b0, 32'h51});
        chk(rd_ack == 1'b0, "R8 invalid word is a miss", 128'(rd_ack), 128'(0));
        @(negedge clk);
        chk(rd_ack && rd_data == (32'h51 ^ KEY), "R8 memory read data",
            {rd_ack, rd_data}, {1'b1, 32'h51 ^ KEY});
        @(posedge clk); #1 rd_req = 1'b0;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk_drain(base + 0, 32'h50, 4'b0001, {96'h0, 32'hAAAA_0050}, "R5 R9 after read");
        chk_drain(base + 1, 32'h70, 4'b0001, {96'h0, 32'hAAAA_0070}, "R5 R9 second");

        // R6: full mask releases a lone slot at once
        base = log_n;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1 wr_valid = 1'b1; wr_addr = 32'h80 + k; wr_data = 32'hC0 + k;
        end
        @(posedge clk); #1 wr_valid = 1'b0;
        @(negedge clk);
        chk(mem_cmd_valid && mem_cmd_we && mem_cmd_wmask == 4'hF && mem_cmd_addr == 32'h80,
            "R6 full block offered", {mem_cmd_valid, mem_cmd_we, mem_cmd_wmask, mem_cmd_addr},
            {1'b1, 1'b1, 4'hF, 32'h80});
        @(negedge clk);
        chk_drain(base, 32'h80, 4'hF, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, "R5 R6 full block");

        // R6: lone partial slot waits for the age limit
        repeat (4) @(posedge clk);
        base = log_n;
        @(posedge clk); #1 wr_valid = 1'b1; wr_addr = 32'h92; wr_data = 32'hBEEF_0092;
        @(posedge clk); #1 wr_valid = 1'b0;
        early = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (mem_cmd_valid) early++;
        end
        chk(early == 0, "R6 lone slot held", 128'(early), 128'(0));
        seen = 1'b0;
        for (int c = 0; c < 12 && !seen; c++) begin
            @(negedge clk);
            if (log_n > base) seen = 1'b1;
        end
        chk(seen, "R6 aged slot released", 128'(seen), 128'(1));
        chk_drain(base, 32'h90, 4'b0100, {32'h0, 32'hBEEF_0092, 64'h0}, "R6 aged drain");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule